// File: doc/BRIEF.md
# Thermometer-to-Binary Encoder with Pseudo-Random Test Pattern

This block sits after a bank of fifteen comparators that sample an analog input on every sample clock. Each clock it takes the 15-bit thermometer word from the comparators and turns it into a 4-bit binary sample. The block counts the ones in the word, so a single out-of-place comparator (a bubble) still gives a value that rises and falls with the input.

The block also holds a 7-stage linear feedback shift register. When the pattern-enable input is high, the register steps four times per sample clock. The four new bits replace the encoded sample at the output, so a receiver downstream can align its parallel lanes against a known sequence. When the enable is low, the generator keeps its state and the encoded sample is passed through. The output is registered in both modes.

Top module: `therm_prbs_encoder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `code_out` becomes 0 and the generator state becomes 7'h7F. With `pat_en` high from the first cycle after reset, the first two output words are 4'b0000 and then 4'b0100.
- R2: With `pat_en` low, `code_out` equals the number of ones in `therm_in`. All zeros gives 0 and all fifteen ones gives 15.
- R3: A thermometer word with a bubble (a 0 below some 1, or a 1 above some 0) encodes to its count of ones.
- R4: Each generator step computes a new bit as the XOR of stage 7 and stage 6. That bit enters stage 1, and every stage k moves to stage k+1.
- R5: The generated bit stream repeats with a period of 127 bits. With `pat_en` held high, output words therefore repeat every 127 cycles and never show an all-zero state lock-up.
- R6: When `pat_en` is high at an edge, `code_out` takes the four bits produced in that cycle and `therm_in` is ignored.
- R7: When `pat_en` is low at an edge, the generator state does not change. After the enable returns high, the sequence continues where it stopped.
- R8: Within one cycle, the first generated bit goes to `code_out[0]` and the fourth goes to `code_out[3]`. Bit 3 is the MSB of the binary sample.
- R9: `code_out` reflects the inputs sampled at the previous rising edge: exactly one cycle of latency in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| therm_in | input | 15 | Thermometer word from the comparators |
| pat_en | input | 1 | 1 selects and runs the test pattern, 0 passes encoded data |
| code_out | output | 4 | Registered binary sample or pattern nibble |

## Verification
The hardest case to reach from the ports is resuming the generator after a pause. The bench must show that the state froze and then continued from the same point, but it can only see that state through the output while the enable is high. The stimulus therefore switches `pat_en` off for runs of varying length, drives changing thermometer words during each pause, and then re-enables. A behavioural model that advanced or reset its state would then disagree on the next pattern word. A run of more than two periods with the enable held high exposes the 127-cycle repeat.

// File: rtl/therm_prbs_pkg.sv
// Package: shared widths and constants for the thermometer encoder with
// test-pattern substitution. Assumes the thermometer width is 2**N - 1.
package therm_prbs_pkg;
    localparam int THERM_W   = 15;
    localparam int CODE_W    = $clog2(THERM_W + 1);
    localparam int LFSR_W    = 7;
    localparam int TAP_HI    = 7;
    localparam int TAP_LO    = 6;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 7'h7F;
endpackage

// File: rtl/therm_popcount.sv
// Module: therm_popcount
// Converts a thermometer word to binary by counting its ones. A count is
// bubble tolerant, so an out-of-place bit moves the result by at most one.
// Assumes OUT_W is wide enough to hold IN_W. Purely combinational.
module therm_popcount #(
    parameter int IN_W  = 15,
    parameter int OUT_W = $clog2(IN_W + 1)
) (
    input  logic [IN_W-1:0]  therm,
    output logic [OUT_W-1:0] count
);
    // Add up the set bits of the thermometer word.
    always_comb begin
        count = '0;
        for (int i = 0; i < IN_W; i++) begin
            count = count + OUT_W'(therm[i]);
        end
    end
endmodule

// File: rtl/prbs_stepper.sv
// Module: prbs_stepper
// Fibonacci LFSR that advances STEPS times per clock while enabled and holds
// otherwise. Stage k is state[k-1]. The new bit is stage TAP_HI XOR stage
// TAP_LO and it enters stage 1. bits[0] is the first bit produced in the
// cycle. Assumes a non-zero SEED. Reset is synchronous, active low.
module prbs_stepper #(
    parameter int W                  = 7,
    parameter int TAP_HI             = 7,
    parameter int TAP_LO             = 6,
    parameter int STEPS              = 4,
    parameter logic [W-1:0] SEED     = 7'h7F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [STEPS-1:0] bits
);
    logic [W-1:0] state;
    logic [W-1:0] chain [STEPS+1];

    assign chain[0] = state;

    // Unroll the per-clock steps into a chain of shifted states.
    for (genvar s = 0; s < STEPS; s++) begin : g_step
        logic fb;
        assign fb           = chain[s][TAP_HI-1] ^ chain[s][TAP_LO-1];
        assign chain[s+1]   = {chain[s][W-2:0], fb};
        assign bits[s]      = fb;
    end

    // Load the seed on reset, advance when enabled, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (en) begin
            state <= chain[STEPS];
        end
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> state != '0);                                  // R5
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !en) |=> $stable(state));                      // R7
    AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && en) |=> state[W-1:STEPS] == $past(state[W-1-STEPS:0])); // R4
endmodule

// File: rtl/code_select_reg.sv
// Module: code_select_reg
// Per-bit 2:1 selector between encoded sample and pattern bit, followed by
// the output register. Adds one cycle. Synchronous active-low reset to zero.
module code_select_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_pat,
    input  logic [W-1:0] enc,
    input  logic [W-1:0] pat,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic d;
        assign d = sel_pat ? pat[b] : enc[b];
        // Register one selected output bit.
        always_ff @(posedge clk) begin
            if (!rst_n) q[b] <= 1'b0;
            else        q[b] <= d;
        end
    end
endmodule

// File: rtl/therm_prbs_encoder.sv
// Module: therm_prbs_encoder (top)
// Encodes a thermometer word to binary, or substitutes pattern nibbles from
// a PRBS-7 generator when pat_en is high. The same enable runs the generator
// and steers the selector. Output is registered, latency one cycle.
module therm_prbs_encoder
    import therm_prbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [THERM_W-1:0] therm_in,
    input  logic              pat_en,
    output logic [CODE_W-1:0]  code_out
);
    logic [CODE_W-1:0] enc_code;
    logic [CODE_W-1:0] pat_bits;

    therm_popcount #(.IN_W(THERM_W), .OUT_W(CODE_W)) u_enc (
        .therm (therm_in),
        .count (enc_code)
    );

    prbs_stepper #(
        .W(LFSR_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO),
        .STEPS(CODE_W), .SEED(LFSR_SEED)
    ) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (pat_en),
        .bits  (pat_bits)
    );

    code_select_reg #(.W(CODE_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_pat (pat_en),
        .enc     (enc_code),
        .pat     (pat_bits),
        .q       (code_out)
    );

    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(!rst_n) |-> code_out == '0);                               // R1
    AST_ENC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!pat_en)) |->
            code_out == CODE_W'($countones($past(therm_in))));           // R9
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!pat_en) && $past(therm_in) == '1) |->
            code_out == '1);                                            // R2
endmodule

// File: tb/test_therm_prbs_encoder.sv
module test_therm_prbs_encoder;
    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] therm_in = '0;
    logic        pat_en = 1'b0;
    logic [3:0]  code_out;

    int checks = 0;
    int errors = 0;
    bit [6:0] m_state;
    logic [3:0] pat_hist [$];

    therm_prbs_encoder i_therm_prbs_encoder (
        .clk(clk), .rst_n(rst_n), .therm_in(therm_in),
        .pat_en(pat_en), .code_out(code_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: code_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: four steps of x^7+x^6+1, first bit to LSB.
    function automatic logic [3:0] model_pat();
        logic [3:0] r;
        for (int k = 0; k < 4; k++) begin
            bit nb;
            nb = m_state[6] ^ m_state[5];
            m_state = {m_state[5:0], nb};
            r[k] = nb;
        end
        return r;
    endfunction

    // Drive one cycle at the falling edge, compare after the next rising edge.
    task automatic cycle(input logic [14:0] t, input logic en, input string req);
        logic [3:0] exp;
        therm_in = t;
        pat_en   = en;
        if (en) begin
            exp = model_pat();
            pat_hist.push_back(exp);
        end else begin
            exp = 4'($countones(t));
        end
        @(posedge clk);
        @(negedge clk);
        check(req, code_out, exp);
    endtask

    function automatic logic [14:0] therm_of(input int n);
        logic [14:0] v;
        v = '0;
        for (int i = 0; i < n; i++) v[i] = 1'b1;
        return v;
    endfunction

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        rst_n = 1'b0; pat_en = 1'b1; therm_in = '1;
        repeat (3) @(negedge clk);
        check("R1 reset", code_out, 4'b0000);
        rst_n = 1'b1;
        m_state = 7'h7F;

        // R1/R8: first two pattern words from the seed, worked out by hand
        therm_in = '1; pat_en = 1'b1;
        void'(model_pat());
        @(posedge clk); @(negedge clk);
        check("R1 first word", code_out, 4'b0000);
        void'(model_pat());
        @(posedge clk); @(negedge clk);
        check("R8 second word", code_out, 4'b0100);

        // R2/R9: every thermometer level, pattern off
        for (int n = 0; n <= 15; n++) cycle(therm_of(n), 1'b0, "R2 level");
        cycle(15'h0000, 1'b0, "R2 all zeros");
        cycle(15'h7FFF, 1'b0, "R2 all ones");

        // R3: bubbles
        cycle(15'b000000001101111, 1'b0, "R3 bubble low");
        cycle(15'b000001000111111, 1'b0, "R3 bubble high");
        cycle(15'b011111111111111, 1'b0, "R3 top gap");

        // R6/R4: pattern mode with changing thermometer input
        for (int i = 0; i < 20; i++) cycle(15'(i * 1237), 1'b1, "R6 pattern");

        // R7: pauses of varying length, then resume
        for (int p = 1; p <= 5; p++) begin
            for (int i = 0; i < p; i++) cycle(therm_of((p * 3 + i) % 16), 1'b0, "R7 paused");
            for (int i = 0; i < 3; i++) cycle(15'h2AAA, 1'b1, "R7 resume");
        end

        // R9: alternate modes every cycle
        for (int i = 0; i < 16; i++) cycle(therm_of(i), i[0], "R9 alternate");

        // R5: long run, then period check on recorded words
        for (int i = 0; i < 300; i++) cycle(15'h1234, 1'b1, "R5 run");
        for (int i = 0; i + 127 < pat_hist.size(); i++) begin
            checks++;
            if (pat_hist[i] !== pat_hist[i + 127]) begin
                errors++;
                $display("FAIL R5 period: word %0d=%b expected=%b", i + 127, pat_hist[i + 127], pat_hist[i]);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule